// File: doc/BRIEF.md
# Page Sharing Directory Controller

This block holds the sharing record for a small set of memory pages in a machine whose caches are kept consistent by software. For every page it stores which processors have a read mapping and which have a write mapping. From these maps it derives one of four base states: uncached, shared, dirty or weak. A separate safe/unsafe flag sits beside the base state, and two small counters drive the hysteresis between safe and unsafe. Processors send four kinds of request: read fault, write fault, unmap-at-acquire and unsafe check. For each request the block returns the page's new state and a bitmap of the processors that must receive a write notice.

A page that is safe posts write notices every time it becomes weak. If it does this more often than a programmable limit allows, it turns unsafe. While unsafe, it stops posting notices, and its sharers instead poll it with checks at acquire time. If those checks find the page not weak more times than a second limit allows, the page becomes safe again. Each request holds a per-page lock from acceptance until its write-back. A request to a locked page is held off through `req_ready`. Requests to other pages flow at one per cycle.

Top module: `page_dir`

## Requirements
- R1: After reset every page is uncached and safe with empty maps, `req_ready` is high, `rsp_valid` is low, and both limits hold 3.
- R2: A read fault adds the requester to the page's read map. With no write mapping and at least one mapping the base state is shared; the base code on `rsp_base` is 0 uncached, 1 shared, 2 dirty, 3 weak.
- R3: A write fault on a page with no mappings grants only a read mapping, so the page goes to shared, and a later read by another processor leaves it shared.
- R4: A write fault on a mapped page grants the requester read and write mappings. If the requester is then the only holder the page is dirty. If there are two or more holders the page is weak.
- R5: When a safe page moves from a non-weak state to weak, `rsp_notify` has bit i set for every processor i that holds a mapping, except the requester, and the notice count increments.
- R6: If that increment makes the notice count exceed the notice limit, the page becomes unsafe (`rsp_unsafe`=1) and the notice count clears. While unsafe, a move to weak gives an all-zero `rsp_notify`.
- R7: A check on an unsafe page that is weak clears the check count. A check on an unsafe page that is not weak increments it. When the count exceeds the check limit the page returns to safe and the count clears.
- R8: An unmap-at-acquire removes both of the requester's mappings; when no mapping remains the page is uncached.
- R9: While a request to a page is in flight, `req_ready` is low for that page; a request to another page is accepted.
- R10: A request accepted at edge k produces `rsp_valid` for one cycle after edge k+2, carrying the page number; `rsp_notify` is zero whenever no notice is due.
- R11: `cfg_we` loads both limits, and later transitions use the new values.
- R12: A check on a safe page changes nothing and returns the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load both limit registers |
| cfg_notice_lim | input | CW | New notice limit |
| cfg_check_lim | input | CW | New check limit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target page not locked |
| req_op | input | 2 | 0 read fault, 1 write fault, 2 unmap at acquire, 3 unsafe check |
| req_proc | input | log2(NPROC) | Requesting processor |
| req_page | input | log2(NPAGE) | Target page |
| rsp_valid | output | 1 | Response present |
| rsp_page | output | log2(NPAGE) | Page of the response |
| rsp_base | output | 2 | New base state |
| rsp_unsafe | output | 1 | New unsafe flag |
| rsp_notify | output | NPROC | Processors to receive a write notice |

## Verification
The hardest conditions to reach from the ports are the two hysteresis edges. The first is the weak entry that turns a page unsafe while it still posts notices. The second is the check that turns the page safe again. Both take a long history of transitions on a single page. The stimulus drives one page repeatedly through read, write and two unmaps, so it becomes weak and then uncached over and over, until the notice limit is passed. It then pairs one check made while weak with a run of checks made while uncached. A later part lowers the notice limit to zero and shows that the first weak entry then turns the page unsafe at once. The lock is exercised with back-to-back requests to the same page and to different pages.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    PG_UNC  = 2'd0,
    PG_SHR  = 2'd1,
    PG_DIR  = 2'd2,
    PG_WEAK = 2'd3
  } pg_base_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_ACQ = 2'd2,
    OP_CHK = 2'd3
  } pg_op_e;

  localparam logic [3:0] LIM_RESET = 4'd3;
endpackage

// File: rtl/pcd_cfg.sv
module pcd_cfg #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] notice_in,
  input  logic [CW-1:0] check_in,
  output logic [CW-1:0] notice_lim,
  output logic [CW-1:0] check_lim
);
  logic [CW-1:0] notice_d, check_d;

  always_comb begin
    notice_d = notice_lim;
    check_d  = check_lim;
    if (we) begin
      notice_d = notice_in;
      check_d  = check_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notice_lim <= CW'(3);
      check_lim  <= CW'(3);
    end else begin
      notice_lim <= notice_d;
      check_lim  <= check_d;
    end
  end
endmodule

// File: rtl/pcd_lock.sv
module pcd_lock #(
  parameter int NPAGE = 4,
  localparam int GW = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [GW-1:0]    set_idx,
  input  logic             clr_en,
  input  logic [GW-1:0]    clr_idx,
  output logic [NPAGE-1:0] held
);
  for (genvar g = 0; g < NPAGE; g++) begin : g_lk
    logic d;
    always_comb begin
      d = held[g];
      if (clr_en && clr_idx == GW'(g)) d = 1'b0;
      if (set_en && set_idx == GW'(g)) d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held[g] <= 1'b0;
      else        held[g] <= d;
    end
  end
endmodule

// File: rtl/pcd_store.sv
module pcd_store #(
  parameter int NPAGE = 4,
  parameter int NPROC = 4,
  parameter int CW    = 4,
  localparam int GW = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GW-1:0]    raddr,
  output logic [NPROC-1:0] r_rd,
  output logic [NPROC-1:0] r_wr,
  output logic             r_unsafe,
  output logic [CW-1:0]    r_ncnt,
  output logic [CW-1:0]    r_ccnt,
  input  logic             we,
  input  logic [GW-1:0]    waddr,
  input  logic [NPROC-1:0] w_rd,
  input  logic [NPROC-1:0] w_wr,
  input  logic             w_unsafe,
  input  logic [CW-1:0]    w_ncnt,
  input  logic [CW-1:0]    w_ccnt
);
  logic [NPROC-1:0] rd_q [NPAGE];
  logic [NPROC-1:0] wr_q [NPAGE];
  logic             un_q [NPAGE];
  logic [CW-1:0]    nc_q [NPAGE];
  logic [CW-1:0]    cc_q [NPAGE];

  for (genvar g = 0; g < NPAGE; g++) begin : g_pg
    logic en;
    assign en = we && (waddr == GW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q[g] <= '0;
        wr_q[g] <= '0;
        un_q[g] <= 1'b0;
        nc_q[g] <= '0;
        cc_q[g] <= '0;
      end else if (en) begin
        rd_q[g] <= w_rd;
        wr_q[g] <= w_wr;
        un_q[g] <= w_unsafe;
        nc_q[g] <= w_ncnt;
        cc_q[g] <= w_ccnt;
      end
    end
  end

  always_comb begin
    r_rd     = rd_q[raddr];
    r_wr     = wr_q[raddr];
    r_unsafe = un_q[raddr];
    r_ncnt   = nc_q[raddr];
    r_ccnt   = cc_q[raddr];
  end
endmodule

// File: rtl/pcd_next.sv
module pcd_next
  import pcd_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int CW    = 4,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  pg_op_e           op,
  input  logic [PW-1:0]    proc,
  input  logic [NPROC-1:0] cur_rd,
  input  logic [NPROC-1:0] cur_wr,
  input  logic             cur_unsafe,
  input  logic [CW-1:0]    cur_ncnt,
  input  logic [CW-1:0]    cur_ccnt,
  input  logic [CW-1:0]    nlim,
  input  logic [CW-1:0]    clim,
  output logic [NPROC-1:0] nxt_rd,
  output logic [NPROC-1:0] nxt_wr,
  output logic             nxt_unsafe,
  output logic [CW-1:0]    nxt_ncnt,
  output logic [CW-1:0]    nxt_ccnt,
  output pg_base_e         nxt_base,
  output logic [NPROC-1:0] notify
);
  function automatic pg_base_e derive(input logic [NPROC-1:0] rd, input logic [NPROC-1:0] wr);
    logic [NPROC-1:0] h;
    h = rd | wr;
    if (h == '0)                  return PG_UNC;
    else if (wr == '0)            return PG_SHR;
    else if ((h & (h - 1'b1)) == '0) return PG_DIR;
    else                          return PG_WEAK;
  endfunction

  logic [NPROC-1:0] me;
  pg_base_e         old_base;
  logic [CW:0]      ninc, cinc;
  logic             to_weak;

  assign me       = NPROC'(1) << proc;
  assign old_base = derive(cur_rd, cur_wr);
  assign ninc     = {1'b0, cur_ncnt} + 1'b1;
  assign cinc     = {1'b0, cur_ccnt} + 1'b1;

  always_comb begin
    nxt_rd = cur_rd;
    nxt_wr = cur_wr;
    unique case (op)
      OP_RD:  nxt_rd = cur_rd | me;
      OP_WR: begin
        nxt_rd = cur_rd | me;
        if ((cur_rd | cur_wr) != '0) nxt_wr = cur_wr | me;
      end
      OP_ACQ: begin
        nxt_rd = cur_rd & ~me;
        nxt_wr = cur_wr & ~me;
      end
      default: ;
    endcase
  end

  assign nxt_base = derive(nxt_rd, nxt_wr);
  assign to_weak  = (nxt_base == PG_WEAK) && (old_base != PG_WEAK);

  always_comb begin
    nxt_unsafe = cur_unsafe;
    nxt_ncnt   = cur_ncnt;
    nxt_ccnt   = cur_ccnt;
    notify     = '0;
    if (to_weak && !cur_unsafe) begin
      notify = (nxt_rd | nxt_wr) & ~me;
      if (ninc > {1'b0, nlim}) begin
        nxt_unsafe = 1'b1;
        nxt_ncnt   = '0;
      end else begin
        nxt_ncnt = ninc[CW-1:0];
      end
    end
    if (op == OP_CHK && cur_unsafe) begin
      if (old_base == PG_WEAK) begin
        nxt_ccnt = '0;
      end else if (cinc > {1'b0, clim}) begin
        nxt_unsafe = 1'b0;
        nxt_ccnt   = '0;
      end else begin
        nxt_ccnt = cinc[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/page_dir.sv
module page_dir
  import pcd_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NPAGE = 4,
  parameter int CW    = 4,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int GW = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_notice_lim,
  input  logic [CW-1:0]    cfg_check_lim,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [PW-1:0]    req_proc,
  input  logic [GW-1:0]    req_page,
  output logic             rsp_valid,
  output logic [GW-1:0]    rsp_page,
  output logic [1:0]       rsp_base,
  output logic             rsp_unsafe,
  output logic [NPROC-1:0] rsp_notify
);
  logic [CW-1:0]    nlim, clim;
  logic [NPAGE-1:0] locked;
  logic             accept;

  logic             s_valid;
  pg_op_e           s_op;
  logic [PW-1:0]    s_proc;
  logic [GW-1:0]    s_page;
  logic             s_valid_d;
  pg_op_e           s_op_d;
  logic [PW-1:0]    s_proc_d;
  logic [GW-1:0]    s_page_d;

  logic [NPROC-1:0] c_rd, c_wr, n_rd, n_wr, n_notify;
  logic             c_un, n_un;
  logic [CW-1:0]    c_nc, c_cc, n_nc, n_cc;
  pg_base_e         n_base;

  logic             o_valid_d, o_un_d;
  logic [GW-1:0]    o_page_d;
  logic [1:0]       o_base_d;
  logic [NPROC-1:0] o_notify_d;

  pcd_cfg #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .notice_in(cfg_notice_lim), .check_in(cfg_check_lim),
    .notice_lim(nlim), .check_lim(clim)
  );

  assign req_ready = !locked[req_page];
  assign accept    = req_valid && req_ready;

  pcd_lock #(.NPAGE(NPAGE)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept), .set_idx(req_page),
    .clr_en(s_valid), .clr_idx(s_page),
    .held(locked)
  );

  always_comb begin
    s_valid_d = accept;
    s_op_d    = s_op;
    s_proc_d  = s_proc;
    s_page_d  = s_page;
    if (accept) begin
      s_op_d   = pg_op_e'(req_op);
      s_proc_d = req_proc;
      s_page_d = req_page;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_op    <= OP_RD;
      s_proc  <= '0;
      s_page  <= '0;
    end else begin
      s_valid <= s_valid_d;
      s_op    <= s_op_d;
      s_proc  <= s_proc_d;
      s_page  <= s_page_d;
    end
  end

  pcd_store #(.NPAGE(NPAGE), .NPROC(NPROC), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .raddr(s_page),
    .r_rd(c_rd), .r_wr(c_wr), .r_unsafe(c_un), .r_ncnt(c_nc), .r_ccnt(c_cc),
    .we(s_valid), .waddr(s_page),
    .w_rd(n_rd), .w_wr(n_wr), .w_unsafe(n_un), .w_ncnt(n_nc), .w_ccnt(n_cc)
  );

  pcd_next #(.NPROC(NPROC), .CW(CW)) u_next (
    .op(s_op), .proc(s_proc),
    .cur_rd(c_rd), .cur_wr(c_wr), .cur_unsafe(c_un),
    .cur_ncnt(c_nc), .cur_ccnt(c_cc),
    .nlim(nlim), .clim(clim),
    .nxt_rd(n_rd), .nxt_wr(n_wr), .nxt_unsafe(n_un),
    .nxt_ncnt(n_nc), .nxt_ccnt(n_cc), .nxt_base(n_base),
    .notify(n_notify)
  );

  always_comb begin
    o_valid_d  = s_valid;
    o_page_d   = rsp_page;
    o_base_d   = rsp_base;
    o_un_d     = rsp_unsafe;
    o_notify_d = '0;
    if (s_valid) begin
      o_page_d   = s_page;
      o_base_d   = n_base;
      o_un_d     = n_un;
      o_notify_d = n_notify;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_page   <= '0;
      rsp_base   <= 2'd0;
      rsp_unsafe <= 1'b0;
      rsp_notify <= '0;
    end else begin
      rsp_valid  <= o_valid_d;
      rsp_page   <= o_page_d;
      rsp_base   <= o_base_d;
      rsp_unsafe <= o_un_d;
      rsp_notify <= o_notify_d;
    end
  end
endmodule

// File: rtl/page_dir_chk.sv
module page_dir_chk #(
  parameter int NPROC = 4,
  parameter int NPAGE = 4,
  localparam int GW = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [GW-1:0]    req_page,
  input logic             s_valid,
  input logic [GW-1:0]    s_page,
  input logic             rsp_valid,
  input logic [1:0]       rsp_base,
  input logic [NPROC-1:0] rsp_notify
);
  // R9: an in-flight page is not accepted again
  a_r9_locked_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && req_page == s_page) |-> !req_ready);

  // R10: an accepted request answers two edges later
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 rsp_valid);

  // R10: every response traces back to an acceptance
  a_r10_origin: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready, 2));

  // R10: no notice without a response
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_notify == '0);

  // R5: notices are only posted on a page that is weak
  a_r5_notify_weak: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_notify != '0) |-> rsp_base == 2'd3);

  // R8: an uncached page has no one to notify
  a_r8_unc_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_base == 2'd0) |-> rsp_notify == '0);
endmodule

bind page_dir page_dir_chk #(.NPROC(NPROC), .NPAGE(NPAGE)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
  .s_valid(s_valid), .s_page(s_page),
  .rsp_valid(rsp_valid), .rsp_base(rsp_base), .rsp_notify(rsp_notify)
);

// File: tb/page_dir_test.sv
`timescale 1ns/1ps
module page_dir_test;
  localparam int NPROC = 4;
  localparam int NPAGE = 4;
  localparam int CW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_notice_lim = '0, cfg_check_lim = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [1:0] req_proc = '0;
  logic [1:0] req_page = '0;
  logic rsp_valid;
  logic [1:0] rsp_page;
  logic [1:0] rsp_base;
  logic rsp_unsafe;
  logic [NPROC-1:0] rsp_notify;

  always #2.5 clk = ~clk;

  page_dir #(.NPROC(NPROC), .NPAGE(NPAGE), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_notice_lim(cfg_notice_lim), .cfg_check_lim(cfg_check_lim),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_proc(req_proc), .req_page(req_page),
    .rsp_valid(rsp_valid), .rsp_page(rsp_page), .rsp_base(rsp_base),
    .rsp_unsafe(rsp_unsafe), .rsp_notify(rsp_notify)
  );

  int checks = 0, failures = 0, cyc = 0, stalls = 0;
  bit done = 0;

  // reference model
  int mrd [NPAGE], mwr [NPAGE], mun [NPAGE], mnot [NPAGE], mchk [NPAGE];
  int nlim = 3, clim = 3;

  int q_due[$], q_pg[$], q_base[$], q_un[$], q_ntf[$];
  string q_tag[$];

  function automatic int base_of(int rd, int wr);
    int h = rd | wr;
    int n = 0;
    for (int i = 0; i < NPROC; i++) if (h[i]) n++;
    if (n == 0) return 0;
    if (wr == 0) return 1;
    if (n == 1) return 2;
    return 3;
  endfunction

  task automatic model_step(input int op, input int p, input int pg, input string tag);
    int me = 1 << p;
    int b0 = base_of(mrd[pg], mwr[pg]);
    int b1, ntf;
    if (op == 0) mrd[pg] |= me;
    else if (op == 1) begin
      if ((mrd[pg] | mwr[pg]) == 0) mrd[pg] |= me;
      else begin mrd[pg] |= me; mwr[pg] |= me; end
    end else if (op == 2) begin
      mrd[pg] &= ~me; mwr[pg] &= ~me;
    end
    b1 = base_of(mrd[pg], mwr[pg]);
    ntf = 0;
    if (op == 3 && mun[pg] != 0) begin
      if (b0 == 3) mchk[pg] = 0;
      else begin
        mchk[pg]++;
        if (mchk[pg] > clim) begin mun[pg] = 0; mchk[pg] = 0; end
      end
    end else if (b1 == 3 && b0 != 3 && mun[pg] == 0) begin
      ntf = (mrd[pg] | mwr[pg]) & ~me;
      mnot[pg]++;
      if (mnot[pg] > nlim) begin mun[pg] = 1; mnot[pg] = 0; end
    end
    q_due.push_back(cyc + 2); q_pg.push_back(pg); q_base.push_back(b1);
    q_un.push_back(mun[pg]); q_ntf.push_back(ntf); q_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // response comparison every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_due.size() != 0 && q_due[0] == cyc) begin
        check(rsp_valid && rsp_page == 2'(q_pg[0]) && rsp_base == 2'(q_base[0]) &&
              rsp_unsafe == q_un[0][0] && rsp_notify == NPROC'(q_ntf[0]), q_tag[0],
              $sformatf("actual v=%0b pg=%0d base=%0d un=%0b ntf=%b expected v=1 pg=%0d base=%0d un=%0d ntf=%b",
                        rsp_valid, rsp_page, rsp_base, rsp_unsafe, rsp_notify,
                        q_pg[0], q_base[0], q_un[0], NPROC'(q_ntf[0])));
        void'(q_due.pop_front()); void'(q_pg.pop_front()); void'(q_base.pop_front());
        void'(q_un.pop_front()); void'(q_ntf.pop_front()); void'(q_tag.pop_front());
      end else if (rsp_valid) begin
        check(1'b0, "R10", $sformatf("actual rsp_valid=1 expected 0 at cycle %0d", cyc));
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic issue(input int op, input int p, input int pg, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_proc = 2'(p); req_page = 2'(pg);
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    model_step(op, p, pg, tag);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPAGE; i++) begin
      mrd[i] = 0; mwr[i] = 0; mun[i] = 0; mnot[i] = 0; mchk[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1",
          $sformatf("actual ready=%0b rsp_valid=%0b expected 1 0", req_ready, rsp_valid));
    rst_n = 1'b1;
    idle(2);
    issue(3, 0, 0, "R1");   // R12: check on a safe uncached page
    issue(3, 1, 2, "R12");
    idle(3);

    // R2 R4 R5: two readers then a writer on page 0
    issue(0, 0, 0, "R2");
    issue(0, 1, 0, "R2");
    issue(1, 2, 0, "R5");
    issue(3, 3, 0, "R12");
    idle(3);

    // R3 R4: write on unmapped page 1 defers, second write makes dirty
    issue(1, 0, 1, "R3");
    issue(0, 1, 1, "R3");
    issue(2, 1, 1, "R8");
    issue(1, 0, 1, "R4");
    issue(0, 2, 1, "R5");
    idle(3);

    // R6: drive page 2 weak repeatedly
    for (int it = 0; it < 5; it++) begin
      issue(0, 0, 2, "R2");
      issue(1, 1, 2, "R6");
      if (it == 4) issue(3, 0, 2, "R7");  // weak check clears count
      issue(2, 0, 2, "R8");
      issue(2, 1, 2, "R8");
    end
    idle(3);
    // R7: checks on unsafe non-weak page
    for (int k = 0; k < 5; k++) issue(3, 2, 2, "R7");
    idle(3);

    // R9: lock stall on same page, none on different page
    begin
      int s0;
      s0 = stalls;
      fork
        begin
          issue(0, 0, 3, "R9");
          issue(0, 1, 3, "R9");
        end
      join
      check(stalls - s0 == 1, "R9", $sformatf("actual stalls=%0d expected 1", stalls - s0));
      s0 = stalls;
      issue(0, 2, 0, "R9");
      check(stalls == s0, "R9", $sformatf("actual stalls=%0d expected 0", stalls - s0));
    end
    idle(3);

    // R11: notice limit 0 makes the first weak entry unsafe
    @(negedge clk);
    cfg_we = 1'b1; cfg_notice_lim = 4'd0; cfg_check_lim = 4'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    nlim = 0; clim = 1;
    issue(0, 0, 3, "R11");
    issue(1, 2, 3, "R11");
    issue(2, 0, 3, "R8");
    issue(2, 1, 3, "R8");
    issue(2, 2, 3, "R8");
    issue(3, 0, 3, "R11");
    issue(3, 0, 3, "R11");
    idle(4);
    check(q_due.size() == 0, "R10", $sformatf("actual pending=%0d expected 0", q_due.size()));

    done = 1;
    summary();
    $finish;
  end
endmodule